// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Arithmetic Scheduler

This block is an issue and execute core for integer arithmetic. It takes one decoded instruction per clock in program order. Each instruction carries an operation code, a destination register and two source registers. The block places the instruction in a free reservation station of the matching kind. The add/subtract kind has three stations and the multiply/divide kind has two. At issue, register names are replaced by station tags. A source whose register has no pending producer is copied in as a value. A source whose register is still pending records the tag of the station that will produce it. A table with one entry per register notes which station will write that register next.

A station starts its fixed-latency computation once it holds both operand values. When the computation ends, the station requests the single shared result bus. The lowest tag wins the bus, and any station that loses keeps its result until it is granted. The granted tag and value go to every waiting station. They also go to the register file, which takes the value only if the register's entry still names that tag. A later writer of a register therefore supersedes an earlier one without a stall. Instructions issue in order, but they complete in whatever order their latencies and operands allow.

Each station is a four-state machine. From FREE, an allocation at issue takes it to WAIT. From WAIT it goes to EXEC once both producer tags are zero. From EXEC it goes to DONE when its latency counter reaches zero. From DONE it returns to FREE at the end of the cycle in which its grant is held.

Top module: `rs_sched_core`

## Requirements
- R1: After reset, register r holds the value r, no register has a pending producer, no result is broadcast, and in_ready is high.
- R2: Operation codes are 0 = add, 1 = subtract (src1 - src2), 2 = multiply, keeping the low DATA_W bits, and 3 = unsigned divide (src1 / src2). All results wrap modulo 2^DATA_W. Dividing by zero yields all ones.
- R3: Codes 0 and 1 use the ADD_STATIONS add stations and codes 2 and 3 use the MUL_STATIONS multiply stations. in_ready is low exactly when no station of the kind selected by in_op is FREE. An instruction held on in_valid is accepted later with its program order kept.
- R4: A new instruction takes the lowest-numbered free station of its kind. Add stations carry tags 1..ADD_STATIONS and multiply stations the tags that follow. Tag 0 means no producer. cdb_tag names the station whose result is on the bus.
- R5: If neither source has a pending producer, the result is on the bus during the cycle that begins LAT+1 clock edges after the accepting edge. LAT is ADD_LAT for add and subtract, MUL_LAT for multiply and DIV_LAT for divide.
- R6: A source whose producer is pending is taken from the bus when that producer broadcasts. After all results drain, the register file equals in-order execution of the accepted stream.
- R7: A later instruction writing the same register supersedes an earlier pending writer. A broadcast from the older writer does not change the register.
- R8: A younger independent instruction with a shorter latency broadcasts before an older long-latency one.
- R9: At most one result is broadcast per cycle, and the lowest requesting tag wins. A station that loses keeps its result and broadcasts in a later cycle.
- R10: An instruction accepted in the cycle in which one of its source tags is on the bus takes that value directly.
- R11: A station becomes FREE at the end of its broadcast cycle. A stalled instruction of that kind is accepted on the next clock edge.
- R12: rd_busy is high while the register at rd_addr has a pending producer. It clears when the matching result is broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | Operation code (see R2) |
| in_dst | input | clog2(NUM_REGS) | Destination register |
| in_src1 | input | clog2(NUM_REGS) | First source register |
| in_src2 | input | clog2(NUM_REGS) | Second source register |
| in_ready | output | 1 | A station of the kind selected by in_op is free |
| rd_addr | input | clog2(NUM_REGS) | Register observation address |
| rd_data | output | DATA_W | Value of register rd_addr |
| rd_busy | output | 1 | Register rd_addr has a pending producer |
| cdb_valid | output | 1 | A result is on the broadcast bus |
| cdb_tag | output | clog2(stations+1) | Tag of the broadcasting station |
| cdb_data | output | DATA_W | Broadcast result value |

## Verification
The bench builds the core with 8-bit data, sixteen registers and latencies of 2, 4 and 7 cycles, keeping three add and two multiply stations. Because sources r0..r7 keep their reset values, every operation can be swept over all 64 operand pairs 0..7. That sweep includes divide by zero and subtract wrap. The multiply latency is the add latency plus the bench's issue spacing, so an add and a multiply finish in the same cycle and the bus arbitration can be exercised. The short divide latency brings full-station stalls, release timing and a long 8-bit wrapping stream against an in-order model within a few thousand cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rs_op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } st_state_e;

endpackage

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DW      = 16,
    parameter int TAG_W   = 3,
    parameter bit IS_MUL  = 1'b0,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 10,
    parameter int DIV_LAT = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  rs_op_e           alloc_op,
    input  logic [DW-1:0]    alloc_vj,
    input  logic [TAG_W-1:0] alloc_qj,
    input  logic [DW-1:0]    alloc_vk,
    input  logic [TAG_W-1:0] alloc_qk,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic [DW-1:0]    bc_data,
    input  logic             grant,
    output logic             busy,
    output logic             req,
    output logic [DW-1:0]    result
);

    localparam int MAX_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int MAX_LAT = (DIV_LAT > MAX_AM) ? DIV_LAT : MAX_AM;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    st_state_e        state, nxt;
    rs_op_e           op;
    logic [DW-1:0]    vj, vk;
    logic [TAG_W-1:0] qj, qk;
    logic [CNT_W-1:0] cnt, lat_m1;
    logic [DW-1:0]    alu_res;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FREE: if (alloc)                     nxt = ST_WAIT;
            ST_WAIT: if (qj == '0 && qk == '0)      nxt = ST_EXEC;
            ST_EXEC: if (cnt == '0)                 nxt = ST_DONE;
            ST_DONE: if (grant)                     nxt = ST_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state != ST_FREE);
        req  = (state == ST_DONE);
    end

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: lat_m1 = CNT_W'(ADD_LAT - 1);
            OP_MUL:         lat_m1 = CNT_W'(MUL_LAT - 1);
            OP_DIV:         lat_m1 = CNT_W'(DIV_LAT - 1);
        endcase
    end

    generate
        if (IS_MUL) begin : g_muldiv
            always_comb begin
                if (op == OP_DIV) alu_res = (vk == '0) ? '1 : vj / vk;
                else              alu_res = vj * vk;
            end
        end else begin : g_addsub
            always_comb alu_res = (op == OP_SUB) ? vj - vk : vj + vk;
        end
    endgenerate

    // operand capture, latency counting, result hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= OP_ADD;
            vj     <= '0;
            vk     <= '0;
            qj     <= '0;
            qk     <= '0;
            cnt    <= '0;
            result <= '0;
        end else begin
            if (alloc) begin
                op <= alloc_op;
                vj <= alloc_vj;
                qj <= alloc_qj;
                vk <= alloc_vk;
                qk <= alloc_qk;
            end else begin
                if (bc_valid && qj != '0 && qj == bc_tag) begin
                    vj <= bc_data;
                    qj <= '0;
                end
                if (bc_valid && qk != '0 && qk == bc_tag) begin
                    vk <= bc_data;
                    qk <= '0;
                end
            end
            if (state == ST_WAIT && nxt == ST_EXEC) cnt <= lat_m1;
            else if (state == ST_EXEC && cnt != '0) cnt <= cnt - 1'b1;
            if (state == ST_EXEC && cnt == '0) result <= alu_res;
        end
    end

endmodule

// File: rtl/rs_cdb_arb.sv
module rs_cdb_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_regfile.sv
module rs_regfile #(
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int TAG_W = 3,
    localparam int RW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    ra1,
    input  logic [RW-1:0]    ra2,
    input  logic [RW-1:0]    ra3,
    output logic [DW-1:0]    rv1,
    output logic [DW-1:0]    rv2,
    output logic [DW-1:0]    rv3,
    output logic [TAG_W-1:0] rt1,
    output logic [TAG_W-1:0] rt2,
    output logic [TAG_W-1:0] rt3,
    input  logic             iss_we,
    input  logic [RW-1:0]    iss_dst,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic [DW-1:0]    bc_data
);

    logic [DW-1:0]    vals [NREG];
    logic [TAG_W-1:0] owner[NREG];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                vals[r]  <= DW'(r);
                owner[r] <= '0;
            end else begin
                if (bc_valid && owner[r] != '0 && owner[r] == bc_tag) begin
                    vals[r]  <= bc_data;
                    owner[r] <= '0;
                end
                if (iss_we && iss_dst == RW'(r)) owner[r] <= iss_tag;
            end
        end
    end

    always_comb begin
        rv1 = vals[ra1];
        rv2 = vals[ra2];
        rv3 = vals[ra3];
        rt1 = owner[ra1];
        rt2 = owner[ra2];
        rt3 = owner[ra3];
    end

endmodule

// File: rtl/rs_sched_core.sv
module rs_sched_core
    import rs_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int NUM_REGS     = 8,
    parameter int ADD_STATIONS = 3,
    parameter int MUL_STATIONS = 2,
    parameter int ADD_LAT      = 2,
    parameter int MUL_LAT      = 10,
    parameter int DIV_LAT      = 40,
    localparam int REG_W       = $clog2(NUM_REGS),
    localparam int NUM_ST      = ADD_STATIONS + MUL_STATIONS,
    localparam int TAG_W       = $clog2(NUM_ST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              in_ready,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_busy,
    output logic              cdb_valid,
    output logic [TAG_W-1:0]  cdb_tag,
    output logic [DATA_W-1:0] cdb_data
);

    logic [NUM_ST-1:0] busy_vec, req_vec, grant_vec, alloc_vec;
    logic [DATA_W-1:0] st_res [NUM_ST];

    logic [DATA_W-1:0] s1_reg, s2_reg, s1_val, s2_val;
    logic [TAG_W-1:0]  s1_own, s2_own, s1_q, s2_q, rd_own;
    logic [TAG_W-1:0]  pick_tag;
    logic              found, accept;

    // lowest free station of the requested kind
    always_comb begin
        found    = 1'b0;
        pick_tag = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (!found && !busy_vec[i] && ((i >= ADD_STATIONS) == in_op[1])) begin
                found    = 1'b1;
                pick_tag = TAG_W'(i + 1);
            end
        end
    end

    assign in_ready = found;
    assign accept   = in_valid && found;

    always_comb begin
        for (int i = 0; i < NUM_ST; i++)
            alloc_vec[i] = accept && (pick_tag == TAG_W'(i + 1));
    end

    // broadcast bus
    always_comb begin
        cdb_valid = 1'b0;
        cdb_tag   = '0;
        cdb_data  = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (grant_vec[i]) begin
                cdb_valid = 1'b1;
                cdb_tag   = TAG_W'(i + 1);
                cdb_data  = st_res[i];
            end
        end
    end

    // source operand resolution, with same-cycle bus bypass
    always_comb begin
        s1_val = s1_reg;
        s1_q   = '0;
        if (s1_own != '0) begin
            if (cdb_valid && cdb_tag == s1_own) s1_val = cdb_data;
            else begin
                s1_val = '0;
                s1_q   = s1_own;
            end
        end
        s2_val = s2_reg;
        s2_q   = '0;
        if (s2_own != '0) begin
            if (cdb_valid && cdb_tag == s2_own) s2_val = cdb_data;
            else begin
                s2_val = '0;
                s2_q   = s2_own;
            end
        end
    end

    assign rd_busy = (rd_own != '0);

    rs_regfile #(
        .DW(DATA_W), .NREG(NUM_REGS), .TAG_W(TAG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ra1(in_src1), .ra2(in_src2), .ra3(rd_addr),
        .rv1(s1_reg), .rv2(s2_reg), .rv3(rd_data),
        .rt1(s1_own), .rt2(s2_own), .rt3(rd_own),
        .iss_we(accept), .iss_dst(in_dst), .iss_tag(pick_tag),
        .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_data(cdb_data)
    );

    rs_cdb_arb #(.N(NUM_ST)) u_arb (
        .req(req_vec), .grant(grant_vec)
    );

    generate
        for (genvar g = 0; g < NUM_ST; g++) begin : g_st
            rs_station #(
                .DW(DATA_W), .TAG_W(TAG_W), .IS_MUL(g >= ADD_STATIONS),
                .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)
            ) u_st (
                .clk(clk), .rst_n(rst_n),
                .alloc(alloc_vec[g]), .alloc_op(rs_op_e'(in_op)),
                .alloc_vj(s1_val), .alloc_qj(s1_q),
                .alloc_vk(s2_val), .alloc_qk(s2_q),
                .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_data(cdb_data),
                .grant(grant_vec[g]),
                .busy(busy_vec[g]), .req(req_vec[g]), .result(st_res[g])
            );
        end
    endgenerate

endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
    parameter int NUM_ST = 5,
    parameter int TAG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [NUM_ST-1:0] req_vec,
    input logic [NUM_ST-1:0] grant_vec,
    input logic [NUM_ST-1:0] busy_vec,
    input logic [NUM_ST-1:0] alloc_vec,
    input logic              in_ready
);

    // R4
    bus_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0 && int'(cdb_tag) <= NUM_ST));

    // R9
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R9
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & ~req_vec) == '0);

    // R9
    lowest_tag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |-> (((grant_vec - 1'b1) & req_vec) == '0));

    // R9
    loser_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_vec & ~grant_vec) != '0) |=> (($past(req_vec & ~grant_vec) & ~req_vec) == '0));

    // R3
    alloc_free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_vec & busy_vec) == '0) && $onehot0(alloc_vec));

    // R3
    no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (alloc_vec == '0));

endmodule

bind rs_sched_core rs_sched_chk #(.NUM_ST(NUM_ST), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .req_vec(req_vec), .grant_vec(grant_vec), .busy_vec(busy_vec),
    .alloc_vec(alloc_vec), .in_ready(in_ready)
);

// File: tb/rs_sched_core_tb.sv
`timescale 1ns/1ps
module rs_sched_core_tb;

    localparam int DW = 8;
    localparam int NR = 16;
    localparam int AL = 2;
    localparam int ML = 4;
    localparam int DL = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = 2'd0;
    logic [3:0] in_dst = '0, in_src1 = '0, in_src2 = '0, rd_addr = '0;
    logic       in_ready, rd_busy, cdb_valid;
    logic [DW-1:0] rd_data, cdb_data;
    logic [2:0] cdb_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] mdl [NR];
    int lg_tag [0:4095];
    int lg_dat [0:4095];
    int lg_cyc [0:4095];
    int nlg = 0;

    rs_sched_core #(
        .DATA_W(DW), .NUM_REGS(NR), .ADD_STATIONS(3), .MUL_STATIONS(2),
        .ADD_LAT(AL), .MUL_LAT(ML), .DIV_LAT(DL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_busy(rd_busy), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_data(cdb_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && cdb_valid && nlg < 4096) begin
            lg_tag[nlg] = int'(cdb_tag);
            lg_dat[nlg] = int'(cdb_data);
            lg_cyc[nlg] = cyc;
            nlg = nlg + 1;
        end
    end

    function automatic logic [DW-1:0] calc(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0:       return a + b;
            1:       return a - b;
            2:       return a * b;
            default: return (b == '0) ? '1 : a / b;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdreg(int r, output int val, output int bsy);
        @(negedge clk);
        rd_addr = r[3:0];
        #1;
        val = int'(rd_data);
        bsy = int'(rd_busy);
    endtask

    task automatic issue(int op, int dst, int s1, int s2, int dly, output int acc);
        repeat (dly) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op[1:0];
        in_dst   = dst[3:0];
        in_src1  = s1[3:0];
        in_src2  = s2[3:0];
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc;
        mdl[dst] = calc(op, mdl[s1], mdl[s2]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected 0 pending cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, b, acc, acc2, acc3, s;
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < NR; r++) begin
            mdl[r] = DW'(r);
            rdreg(r, v, b);
            chk("R1 value", v, r);
            chk("R1 pending", b, 0);
        end
        chk("R1 bus idle", int'(cdb_valid), 0);
        chk("R1 ready", int'(in_ready), 1);

        // R5 latency, R4 tags
        s = nlg;
        issue(0, 8, 3, 5, 0, acc);
        wait_cyc(12);
        chk("R5 add latency", lg_cyc[s] - acc, AL + 2);
        chk("R4 add tag", lg_tag[s], 1);
        chk("R2 add value", lg_dat[s], 8);
        s = nlg;
        issue(2, 9, 3, 7, 0, acc);
        wait_cyc(12);
        chk("R5 mul latency", lg_cyc[s] - acc, ML + 2);
        chk("R4 mul tag", lg_tag[s], 4);
        chk("R2 mul value", lg_dat[s], 21);
        s = nlg;
        issue(3, 10, 7, 2, 0, acc);
        wait_cyc(14);
        chk("R5 div latency", lg_cyc[s] - acc, DL + 2);
        chk("R2 div value", lg_dat[s], 3);

        // R12 pending flag
        issue(3, 11, 7, 1, 0, acc);
        rdreg(11, v, b);
        chk("R12 pending set", b, 1);
        wait_cyc(15);
        rdreg(11, v, b);
        chk("R12 pending cleared", b, 0);
        chk("R12 value", v, 7);

        // R2 sweep over all ops and operand pairs 0..7
        for (int a = 0; a < 8; a++) begin
            for (int c = 0; c < 8; c++) begin
                for (int op = 0; op < 4; op++) begin
                    int d;
                    d = 8 + ((a + c + op) % 8);
                    s = nlg;
                    issue(op, d, a, c, 0, acc);
                    wait_cyc((op < 2 ? AL : (op == 2 ? ML : DL)) + 3);
                    chk("R2 sweep bus", lg_dat[s], int'(calc(op, DW'(a), DW'(c))));
                    rdreg(d, v, b);
                    chk("R2 sweep reg", v, int'(mdl[d]));
                end
            end
        end

        // R4 lowest-free allocation across add stations
        s = nlg;
        issue(0, 8, 1, 1, 0, acc);
        issue(0, 9, 1, 2, 0, acc);
        issue(0, 10, 1, 3, 0, acc);
        issue(0, 11, 1, 4, 0, acc);
        wait_cyc(15);
        chk("R4 first tag", lg_tag[s], 1);
        chk("R4 second tag", lg_tag[s+1], 2);
        chk("R4 third tag", lg_tag[s+2], 3);
        chk("R4 reuse lowest", lg_tag[s+3], 1);
        chk("R4 fourth value", lg_dat[s+3], 5);

        // R3 stall, R11 release
        s = nlg;
        issue(3, 12, 7, 2, 0, acc);
        issue(3, 13, 6, 2, 0, acc2);
        @(negedge clk);
        in_op = 2'd2;
        #1;
        chk("R3 mul full", int'(in_ready), 0);
        in_op = 2'd0;
        #1;
        chk("R3 add free", int'(in_ready), 1);
        issue(2, 14, 2, 3, 0, acc3);
        wait_cyc(20);
        chk("R11 release edge", acc3, lg_cyc[s] + 1);
        chk("R3 order tag", lg_tag[s+2], 4);
        rdreg(14, v, b);
        chk("R3 stalled value", v, int'(mdl[14]));
        rdreg(13, v, b);
        chk("R3 second div", v, 3);

        // R8 out of order, R7 supersede
        s = nlg;
        issue(3, 12, 7, 3, 0, acc);
        issue(0, 12, 1, 2, 0, acc2);
        wait_cyc(20);
        chk("R8 young first", lg_tag[s], 1);
        chk("R8 old second", lg_tag[s+1], 4);
        rdreg(12, v, b);
        chk("R7 younger kept", v, 3);
        chk("R7 no pending", b, 0);

        // R9 simultaneous finish
        s = nlg;
        issue(2, 13, 2, 3, 0, acc);
        issue(0, 14, 4, 5, 0, acc2);
        wait_cyc(15);
        chk("R9 winner tag", lg_tag[s], 1);
        chk("R9 loser tag", lg_tag[s+1], 4);
        chk("R9 winner cycle", lg_cyc[s], acc + ML + 2);
        chk("R9 loser next cycle", lg_cyc[s+1], lg_cyc[s] + 1);
        chk("R9 loser value", lg_dat[s+1], 6);

        // R10 same-cycle capture
        s = nlg;
        issue(0, 8, 1, 2, 0, acc);
        issue(0, 9, 8, 3, 2, acc2);
        wait_cyc(10);
        chk("R10 issue cycle", acc2, acc + AL + 2);
        chk("R10 bus same cycle", lg_cyc[s], acc2);
        rdreg(9, v, b);
        chk("R10 value", v, 6);

        // R6 long stream against in-order model
        x = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            issue(int'(x[31:30]), int'(x[27:24]), int'(x[23:20]), int'(x[19:16]), 0, acc);
        end
        wait_cyc(120);
        for (int r = 0; r < NR; r++) begin
            rdreg(r, v, b);
            chk("R6 stream value", v, int'(mdl[r]));
            chk("R6 drained", b, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule